// File: doc/BRIEF.md
# SDRAM Initialization and Command Sequencer

This block sits on the controller side of a single-data-rate SDRAM that has four banks. It drives the command pins (chip select, row strobe, column strobe and write enable), the bank address, the multiplexed address bus and the write-data bus. It also captures read data. After reset it runs a fixed bring-up sequence: a long NOP period, a precharge of all banks, a set number of auto refreshes, and a mode register write. After that it serves single-word read and write requests from a simple user port. Periodic auto refreshes are interleaved with this traffic.

The controller keeps pages closed. Each access is an activate, then a read or write that carries the auto-precharge flag. A gap timer holds every command until the minimum spacing to the previous one has passed. A small pipeline as long as the CAS latency marks the clock edge on which read data is taken from the bus. Command encodings are written as the 4-bit value {cs_n, ras_n, cas_n, we_n}:

| Command | Encoding |
|---|---|
| NOP | 0111 |
| activate | 0011 |
| read | 0101 |
| write | 0100 |
| precharge | 0010 |
| refresh | 0001 |
| mode set | 0000 |

Top module: `sdram_seq`

## Requirements
- R1: During reset and before the mode register write, the block holds these values. CKE is high, DQM is high, the command is NOP (0111), `init_done`, `req_ready`, `sd_dq_oe` and `rd_valid` are low. DQM goes low from the cycle the mode register write appears, and stays low.
- R2: The first non-NOP command appears no earlier than PWR_CYC cycles after reset release. That command is a precharge (0010) with address bit 10 high, which selects all banks. No other precharge command is ever issued.
- R3: After the precharge come exactly INIT_REFS refresh commands (0001), then one mode register write (0000). The mode write has bank 0 and an address that carries CAS_LAT in bits 6:4, with all other bits zero. This selects burst length 1, sequential order and burst writes.
- R4: No activate and no request acceptance happen before the mode register write. `init_done` is high from the cycle the mode write appears, and stays high.
- R5: The activate (0011) carries the request's bank and its 12-bit row on the address bus. It is followed, at least TRCD cycles later, by a read (0101) or write (0100) to the same bank. That command has the column in address bits 7:0, bit 10 high (auto precharge) and all other bits zero.
- R6: `sd_dq_oe` is high only in the cycle the write command is on the pins. In that cycle `sd_dq_out` equals the accepted write data.
- R7: `rd_valid` pulses for one cycle exactly CAS_LAT+1 cycles after the read command appears on the pins. `rd_data` is the bus value sampled at the clock edge CAS_LAT cycles after the memory takes the command.
- R8: The block never drives the data bus in the cycle in which read data is due, nor in the cycle before it.
- R9: Minimum spacing from each command to the next command:
  - after precharge: TRP cycles
  - after refresh: TRC cycles
  - after mode write: TMRD cycles
  - after a write: TWR+TRP cycles
  - after a read: CAS_LAT+TRP cycles
- R10: After initialization, refreshes recur at most REF_INT plus the longest access time apart, even under a continuous stream of requests. A due refresh wins over a waiting request.
- R11: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Request inputs that change after acceptance have no effect on the addresses or the data of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BA_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request is taken this cycle if valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| init_done | output | 1 | Bring-up finished |
| sd_cke | output | 1 | Clock enable to memory |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | DW | Write data to bus |
| sd_dq_oe | output | 1 | Bus drive enable |
| sd_dq_in | input | DW | Data from bus |

## Verification
The hardest situation to reach is a refresh falling due while user requests arrive back to back. Then the refresh must win over a waiting request, and the delay it suffers stays bounded. The bench floods the request port with alternating writes and reads over all four banks, using a short refresh interval. Refresh periods therefore land at many different points inside an access. The bench also raises a request before bring-up has finished, to show that it is held off. It changes the request inputs right after each acceptance. A behavioural memory model returns read data only in the cycle it is due, so a mistimed capture or a bus collision shows up at once.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_INITREF,
    ST_MODE,
    ST_IDLE,
    ST_ACCESS
  } seq_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int W         = 8,
  parameter int RESET_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RESET_VAL);
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  AST_GAP_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !load) |=> done); // R9

endmodule

// File: rtl/sdram_refresh_tick.sv
module sdram_refresh_tick #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic clear,
  output logic pending
);

  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  assign wrap = enable && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (enable) cnt_d = wrap ? CW'(INTERVAL - 1) : cnt_q - 1'b1;
    if (clear)  pend_d = 1'b0;
    if (wrap)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CW'(INTERVAL - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  AST_REF_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (pending && !clear) |=> pending); // R10

endmodule

// File: rtl/sdram_read_capture.sv
module sdram_read_capture #(
  parameter int CL = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issued,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  logic [CL-1:0] pipe_q, pipe_d;
  logic          take;
  logic [DW-1:0] data_q;
  logic          valid_q;

  generate
    if (CL > 1) begin : g_shift
      assign pipe_d = {pipe_q[CL-2:0], issued};
    end else begin : g_single
      assign pipe_d = issued;
    end
  endgenerate

  assign take = pipe_q[CL-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      pipe_q  <= pipe_d;
      valid_q <= take;
      if (take) data_q <= dq_in;
    end
  end

  assign rd_valid = valid_q;
  assign rd_data  = data_q;

  AST_ONE_READ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pipe_q)); // R7

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int CAS_LAT   = 2,
  parameter int PWR_CYC   = 10000,
  parameter int INIT_REFS = 8,
  parameter int TRP       = 3,
  parameter int TRC       = 9,
  parameter int TMRD      = 2,
  parameter int TRCD      = 3,
  parameter int TWR       = 2,
  parameter int REF_INT   = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             init_done,
  output logic             sd_cke,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [BA_W-1:0]  sd_ba,
  output logic [ROW_W-1:0] sd_addr,
  output logic             sd_dqm,
  output logic [DW-1:0]    sd_dq_out,
  output logic             sd_dq_oe,
  input  logic [DW-1:0]    sd_dq_in
);

  localparam int GAP_MAX = max_of(PWR_CYC, max_of(TRC, max_of(TWR + TRP,
                           max_of(CAS_LAT + TRP, max_of(TRCD, TMRD)))));
  localparam int TW      = $clog2(GAP_MAX + 1);
  localparam int RW      = $clog2(INIT_REFS + 1);
  localparam int AP_BIT  = 10;

  typedef struct packed {
    logic             wr;
    logic [BA_W-1:0]  ba;
    logic [COL_W-1:0] col;
    logic [DW-1:0]    data;
  } held_req_t;

  seq_state_e       state_q, state_d;
  sd_cmd_e          cmd_q, cmd_d;
  logic [BA_W-1:0]  ba_q, ba_d;
  logic [ROW_W-1:0] addr_q, addr_d;
  logic [DW-1:0]    dout_q, dout_d;
  logic             oe_q, oe_d;
  logic             init_q, init_d;
  logic [RW-1:0]    refs_q, refs_d;
  held_req_t        held_q;
  logic             accept;
  logic             t_load;
  logic [TW-1:0]    t_val;
  logic             gap_done;
  logic             ref_pend;
  logic             ref_clr;

  sdram_gap_timer #(.W(TW), .RESET_VAL(PWR_CYC - 1)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(gap_done)
  );

  sdram_refresh_tick #(.INTERVAL(REF_INT)) u_ref (
    .clk(clk), .rst_n(rst_n), .enable(init_q), .clear(ref_clr), .pending(ref_pend)
  );

  sdram_read_capture #(.CL(CAS_LAT), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .issued(cmd_q == CMD_RD), .dq_in(sd_dq_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign req_ready = (state_q == ST_IDLE) && gap_done && !ref_pend;

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    addr_d  = '0;
    dout_d  = dout_q;
    oe_d    = 1'b0;
    init_d  = init_q;
    refs_d  = refs_q;
    t_load  = 1'b0;
    t_val   = '0;
    ref_clr = 1'b0;
    accept  = 1'b0;
    unique case (state_q)
      ST_POWER: if (gap_done) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        t_load         = 1'b1;
        t_val          = TW'(TRP - 1);
        refs_d         = RW'(INIT_REFS);
        state_d        = ST_INITREF;
      end
      ST_INITREF: if (gap_done) begin
        cmd_d  = CMD_REF;
        t_load = 1'b1;
        t_val  = TW'(TRC - 1);
        refs_d = refs_q - 1'b1;
        if (refs_q == RW'(1)) state_d = ST_MODE;
      end
      ST_MODE: if (gap_done) begin
        cmd_d   = CMD_MRS;
        addr_d  = ROW_W'(CAS_LAT) << 4;
        t_load  = 1'b1;
        t_val   = TW'(TMRD - 1);
        init_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE: if (gap_done) begin
        if (ref_pend) begin
          cmd_d   = CMD_REF;
          t_load  = 1'b1;
          t_val   = TW'(TRC - 1);
          ref_clr = 1'b1;
        end else if (req_valid) begin
          accept  = 1'b1;
          cmd_d   = CMD_ACT;
          ba_d    = req_bank;
          addr_d  = req_row;
          t_load  = 1'b1;
          t_val   = TW'(TRCD - 1);
          state_d = ST_ACCESS;
        end
      end
      ST_ACCESS: if (gap_done) begin
        ba_d                = held_q.ba;
        addr_d[COL_W-1:0]   = held_q.col;
        addr_d[AP_BIT]      = 1'b1;
        t_load              = 1'b1;
        state_d             = ST_IDLE;
        if (held_q.wr) begin
          cmd_d  = CMD_WR;
          oe_d   = 1'b1;
          dout_d = held_q.data;
          t_val  = TW'(TWR + TRP - 1);
        end else begin
          cmd_d  = CMD_RD;
          t_val  = TW'(CAS_LAT + TRP - 1);
        end
      end
      default: state_d = ST_POWER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWER;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
      init_q  <= 1'b0;
      refs_q  <= '0;
      held_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      ba_q    <= ba_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      init_q  <= init_d;
      refs_q  <= refs_d;
      if (accept) held_q <= '{wr: req_write, ba: req_bank, col: req_col, data: req_wdata};
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_cke    = 1'b1;
  assign sd_dqm    = !init_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dout_q;
  assign sd_dq_oe  = oe_q;
  assign init_done = init_q;

  AST_ACT_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd_q == CMD_ACT) |-> init_q); // R4
  AST_OE_WITH_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) oe_q |-> (cmd_q == CMD_WR)); // R6
  AST_RW_AUTO_PRE:    assert property (@(posedge clk) disable iff (!rst_n) ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> addr_q[AP_BIT]); // R5
  AST_PRE_ALL_BANKS:  assert property (@(posedge clk) disable iff (!rst_n) (cmd_q == CMD_PRE) |-> (addr_q[AP_BIT] && !init_q)); // R2

  generate
    if (TRCD > 1) begin : g_rcd_chk
      AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n) (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP)); // R5
    end
  endgenerate

endmodule

// File: tb/tb_sdram_seq.sv
module tb_sdram_seq;

  localparam int CL        = 3;
  localparam int PWR_CYC   = 60;
  localparam int INIT_REFS = 2;
  localparam int TRP       = 3;
  localparam int TRC       = 7;
  localparam int TMRD      = 2;
  localparam int TRCD      = 3;
  localparam int TWR       = 2;
  localparam int REF_INT   = 150;
  localparam int SLACK     = TRCD + TWR + TRP + CL + TRP + 4;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [7:0]  req_col;
  logic [15:0] req_wdata;
  logic        req_ready, rd_valid, init_done;
  logic [15:0] rd_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in;

  always #10 clk = ~clk;

  sdram_seq #(
    .DW(16), .BA_W(2), .ROW_W(12), .COL_W(8), .CAS_LAT(CL), .PWR_CYC(PWR_CYC),
    .INIT_REFS(INIT_REFS), .TRP(TRP), .TRC(TRC), .TMRD(TMRD), .TRCD(TRCD),
    .TWR(TWR), .REF_INT(REF_INT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data), .init_done(init_done),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { bit wr; int ba; int row; int col; logic [15:0] d; } req_t;
  typedef struct { int due; logic [15:0] d; } exp_t;

  req_t        acc_q[$];
  req_t        cur;
  exp_t        exp_q[$];
  logic [15:0] mem [int];
  bit          drv_v [16];
  logic [15:0] drv_d [16];
  bit          bank_open [4];
  int          m = 0;
  int          last_cyc = 0;
  logic [3:0]  last_cmd = 4'b0111;
  bit          any_cmd = 0;
  bit          mrs_seen = 0;
  int          mrs_cyc = 0;
  int          refs_init = 0;
  int          post_refs = 0;
  int          last_ref = 0;
  logic [3:0]  pcmd;

  assign pcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  function automatic int min_gap(input logic [3:0] c);
    case (c)
      C_PRE:   return TRP;
      C_REF:   return TRC;
      C_MRS:   return TMRD;
      C_ACT:   return TRCD;
      C_RD:    return CL + TRP;
      C_WR:    return TWR + TRP;
      default: return 1;
    endcase
  endfunction

  function automatic logic [15:0] mem_rd(input int key);
    if (mem.exists(key)) return mem[key];
    return key[15:0] ^ 16'h5A5A;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      m++;
      // bus turnaround against read data (R8)
      chk(!(drv_v[m % 16] && sd_dq_oe), "R8 drive while read data due", 32'(sd_dq_oe), 0);
      chk(!(drv_v[(m + 1) % 16] && sd_dq_oe), "R8 drive one cycle before read data", 32'(sd_dq_oe), 0);
      sd_dq_in <= drv_v[m % 16] ? drv_d[m % 16] : 16'hDEAD;
      drv_v[m % 16] = 0;
      // read return timing and data (R7)
      begin
        bit ev;
        ev = (exp_q.size() > 0) && (exp_q[0].due == m);
        chk(rd_valid == ev, "R7 rd_valid timing", 32'(rd_valid), 32'(ev));
        if (ev && rd_valid) begin
          chk(rd_data == exp_q[0].d, "R7 rd_data", 32'(rd_data), 32'(exp_q[0].d));
          void'(exp_q.pop_front());
        end
      end
      // static pin state
      chk(sd_cke == 1'b1, "R1 cke high", 32'(sd_cke), 1);
      chk(sd_dqm == !(mrs_seen || pcmd == C_MRS), "R1 dqm", 32'(sd_dqm), 32'(!(mrs_seen || pcmd == C_MRS)));
      chk(init_done == (mrs_seen || pcmd == C_MRS), "R4 init_done", 32'(init_done), 32'(mrs_seen || pcmd == C_MRS));
      chk(!(sd_dq_oe && pcmd != C_WR), "R6 oe outside write", 32'(pcmd), 32'(C_WR));
      chk(!(req_ready && !mrs_seen), "R4 ready before init", 32'(req_ready), 0);
      if (req_valid && req_ready)
        acc_q.push_back('{wr: req_write, ba: int'(req_bank), row: int'(req_row), col: int'(req_col), d: req_wdata});
      if (mrs_seen)
        chk(m - last_ref <= REF_INT + SLACK, "R10 refresh interval", 32'(m - last_ref), 32'(REF_INT + SLACK));
      // command stream
      if (pcmd != C_NOP) begin
        if (!any_cmd) begin
          chk(pcmd == C_PRE, "R2 first command", 32'(pcmd), 32'(C_PRE));
          chk(m >= PWR_CYC, "R2 power-on wait", 32'(m), 32'(PWR_CYC));
        end else begin
          chk(m - last_cyc >= min_gap(last_cmd), "R9 command spacing", 32'(m - last_cyc), 32'(min_gap(last_cmd)));
        end
        case (pcmd)
          C_PRE: begin
            chk(!any_cmd, "R2 single precharge", 32'(any_cmd), 0);
            chk(sd_addr[10], "R2 all-bank flag", 32'(sd_addr), 32'h400);
          end
          C_REF: begin
            if (!mrs_seen) refs_init++;
            else begin post_refs++; last_ref = m; end
          end
          C_MRS: begin
            chk(refs_init == INIT_REFS, "R3 init refresh count", 32'(refs_init), 32'(INIT_REFS));
            chk(sd_addr == 12'(CL << 4), "R3 mode word", 32'(sd_addr), 32'(CL << 4));
            chk(sd_ba == 2'b00, "R3 mode bank", 32'(sd_ba), 0);
            mrs_seen = 1; mrs_cyc = m; last_ref = m;
          end
          C_ACT: begin
            chk(mrs_seen, "R4 activate after init", 32'(mrs_seen), 1);
            chk(acc_q.size() > 0, "R11 activate without request", 32'(acc_q.size()), 1);
            if (acc_q.size() > 0) cur = acc_q.pop_front();
            chk(int'(sd_ba) == cur.ba, "R5 activate bank", 32'(sd_ba), 32'(cur.ba));
            chk(int'(sd_addr) == cur.row, "R5 R11 activate row", 32'(sd_addr), 32'(cur.row));
            chk(!bank_open[sd_ba], "R5 bank already open", 32'(bank_open[sd_ba]), 0);
            bank_open[sd_ba] = 1;
          end
          C_RD, C_WR: begin
            int key;
            chk(last_cmd == C_ACT, "R5 access follows activate", 32'(last_cmd), 32'(C_ACT));
            chk(int'(sd_ba) == cur.ba, "R5 access bank", 32'(sd_ba), 32'(cur.ba));
            chk(int'(sd_addr) == (cur.col | 32'h400), "R5 R11 column with auto precharge", 32'(sd_addr), 32'(cur.col | 32'h400));
            chk(bank_open[sd_ba], "R5 access to open bank", 32'(bank_open[sd_ba]), 1);
            chk((pcmd == C_WR) == cur.wr, "R11 access direction", 32'(pcmd), 32'(cur.wr ? C_WR : C_RD));
            bank_open[sd_ba] = 0;
            key = (cur.ba << 20) | (cur.row << 8) | cur.col;
            if (pcmd == C_WR) begin
              chk(sd_dq_oe && sd_dq_out == cur.d, "R6 R11 write data", 32'(sd_dq_out), 32'(cur.d));
              mem[key] = sd_dq_out;
            end else begin
              exp_q.push_back('{due: m + CL + 1, d: mem_rd(key)});
              drv_v[(m + CL) % 16] = 1;
              drv_d[(m + CL) % 16] = mem_rd(key);
            end
          end
          default: chk(0, "R2 unexpected command", 32'(pcmd), 32'(C_NOP));
        endcase
        last_cmd = pcmd; last_cyc = m; any_cmd = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit wr, input int ba, input int row, input int col, input logic [15:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_bank = 2'(ba); req_row = 12'(row);
    req_col = 8'(col); req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0; req_write = ~wr; req_bank = ~req_bank; req_row = ~req_row;
    req_col = ~req_col; req_wdata = ~d;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_bank = 0; req_row = 0; req_col = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd_cke == 1'b1, "R1 reset cke", 32'(sd_cke), 1);
    chk(sd_dqm == 1'b1, "R1 reset dqm", 32'(sd_dqm), 1);
    chk(pcmd == C_NOP, "R1 reset command", 32'(pcmd), 32'(C_NOP));
    chk(!init_done && !req_ready, "R1 reset init/ready", 32'({init_done, req_ready}), 0);
    chk(!sd_dq_oe && !rd_valid, "R1 reset bus/valid", 32'({sd_dq_oe, rd_valid}), 0);
    #1 rst_n = 1;
    // request raised during bring-up must wait (R4)
    do_req(1, 0, 5, 3, 16'h1111);
    do_req(1, 1, 4095, 255, 16'hA5A5);
    do_req(0, 0, 5, 3, 16'h0);
    do_req(0, 1, 4095, 255, 16'h0);
    do_req(1, 3, 0, 0, 16'hFFFF);
    do_req(0, 3, 0, 0, 16'h0);
    do_req(0, 2, 7, 9, 16'h0);
    for (int i = 0; i < 60; i++) begin
      do_req(1, i % 4, (i * 37) % 4096, (i * 11) % 256, 16'(i * 16'h1357 + 3));
      do_req(0, i % 4, (i * 37) % 4096, (i * 11) % 256, 16'h0);
    end
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", 32'(exp_q.size()), 0);
    chk(acc_q.size() == 0, "R11 all requests served", 32'(acc_q.size()), 0);
    chk(post_refs > 0, "R10 refreshes under traffic", 32'(post_refs), 1);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule